// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Fast and Slow Recirculation

This block drives the four gate lines of one full bridge: a high and a low switch on each of two legs. A phase bit picks which diagonal pair conducts. A chopper request says whether the bridge should conduct or recirculate. A mode bit picks fast or slow recirculation, and an enable line can force every switch off. Every gate output is registered.

Switches are turned off at once. A switch is turned on only after the required gap. Whenever some gate must drop, the block drops it at the next clock edge and restarts a dead-time counter. The gates of the new pattern rise only when that counter has run `DEAD_CYC` cycles. This one rule covers every transition: entering and leaving the off interval, reversing the phase, and coming out of reset or disable.

During the off interval there are two recirculation styles. In fast recirculation both conducting switches open, and later only the low switch beside the freewheeling diode is closed. The other leg's low switch stays open, so reverse current cannot build up. In slow recirculation only the conducting low switch opens, and later the second high switch closes, so current circulates through the upper half of the bridge.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `rst_n` is low all four gates are low. After reset is released, the first gate rises at the `DEAD_CYC`-th rising clock edge after release.
- R2: `hi1` and `lo1` are never high together, and `hi2` and `lo2` are never high together.
- R3: A gate that must turn off goes low at the first clock edge that samples the new inputs. No gate rises until its leg partner has been low for at least `DEAD_CYC` cycles.
- R4: With `drive_on` high, `phase` high settles to `hi1`+`lo2` and `phase` low settles to `hi2`+`lo1`, with the other two gates low.
- R5: In fast recirculation (`slow_decay` low, `drive_on` low), both conducting gates fall at the first edge. After `DEAD_CYC` cycles with all gates low, only `lo1` rises (when `phase` is high) or only `lo2` rises (when `phase` is low). `lo1` and `lo2` are never high together.
- R6: In slow recirculation (`slow_decay` high, `drive_on` low), only the conducting low gate falls at the first edge and the conducting high gate stays high. After `DEAD_CYC` cycles the other high gate rises, giving `hi1`+`hi2`. In that state a change of `phase` has no effect.
- R7: When `drive_on` returns high, the recirculation gates fall at the first edge. The conducting pattern of R4 is complete `DEAD_CYC` cycles later.
- R8: A change of `phase` while conducting holds all four gates low for exactly `DEAD_CYC` cycles before the new diagonal rises.
- R9: With `en` low, all four gates are low from the first edge that samples it. After re-enable the pattern rises no earlier than `DEAD_CYC` edges after that disabling edge. If `en` stayed low for longer than that, the pattern rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable; low forces all gates off |
| phase | input | 1 | Diagonal select: 1 = hi1/lo2, 0 = hi2/lo1 |
| drive_on | input | 1 | Chopper request: 1 = conduct, 0 = off interval |
| slow_decay | input | 1 | Recirculation select: 1 = slow, 0 = fast |
| hi1 | output | 1 | High-side gate, leg 1 |
| lo1 | output | 1 | Low-side gate, leg 1 |
| hi2 | output | 1 | High-side gate, leg 2 |
| lo2 | output | 1 | Low-side gate, leg 2 |

## Verification
Some properties are checked by assertions on every cycle. These are: no shoot-through on either leg, no two low gates together, enable forcing all gates off, and a minimum partner-off time before any gate rises. The partner-off time is measured by per-gate idle counters.

Other behaviour depends on the input history, so only the bench scenarios can show it. This covers the exact gate pattern reached in each recirculation mode for both phases, and the intermediate pattern held during each gap. It also covers the exact gap length, the all-off interval on phase reversal, the start-up delay and both re-enable timings.

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
  parameter int DEAD_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic phase,
  input  logic drive_on,
  input  logic slow_decay,
  output logic hi1,
  output logic lo1,
  output logic hi2,
  output logic lo2
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

  // bit order: {hi1, lo1, hi2, lo2}
  logic [3:0]    cur, tgt, kill;
  logic [CW-1:0] cnt;

  always_comb begin
    if (!en)           tgt = 4'b0000;
    else if (drive_on) tgt = phase ? 4'b1001 : 4'b0110;
    else if (slow_decay) tgt = 4'b1010;
    else               tgt = phase ? 4'b0100 : 4'b0001;
  end

  assign kill = cur & ~tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      cnt <= '0;
    end else if (kill != 4'b0000) begin
      cur <= cur & tgt;
      cnt <= '0;
    end else if (cnt < LAST) begin
      cnt <= cnt + 1'b1;
    end else begin
      cur <= tgt;
    end
  end

  assign {hi1, lo1, hi2, lo2} = cur;

  // idle counters: cycles each gate has been low, saturating
  logic [CW-1:0] idle [4];
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rst_n || cur[i])  idle[i] <= '0;
      else if (idle[i] < FULL) idle[i] <= idle[i] + 1'b1;
    end
  end

  assert_leg1_no_shoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi1 && lo1));
  assert_leg2_no_shoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi2 && lo2));
  assert_lows_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo1 && lo2));
  assert_disable_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hi1 && !lo1 && !hi2 && !lo2));

  for (genvar g = 0; g < 4; g++) begin : gap_chk
    assert_partner_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cur[g]) |-> (idle[g ^ 1] >= FULL));
  end
endmodule

// File: tb/hbridge_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hbridge_gate_seq_tb_top;
  localparam int DT = 5;

  logic clk = 0, rst_n = 0, en = 1, phase = 1, drive_on = 1, slow_decay = 0;
  logic hi1, lo1, hi2, lo2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYC(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .drive_on(drive_on),
    .slow_decay(slow_decay), .hi1(hi1), .lo1(lo1), .hi2(hi2), .lo2(lo2));

  function automatic logic [3:0] gates();
    return {hi1, lo1, hi2, lo2};
  endfunction

  task automatic apply(input logic e, input logic p, input logic on, input logic s);
    en = e; phase = p; drive_on = on; slow_decay = s;
  endtask

  // n consecutive samples must all equal exp
  task automatic hold(input logic [3:0] exp, input int n, input string tag);
    logic [3:0] bad = 'x;
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ok && gates() !== exp) begin ok = 0; bad = gates(); end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, bad, exp);
    end
  endtask

  task automatic step(input logic [3:0] mid, input logic [3:0] fin, input string tag);
    hold(mid, DT, {tag, " gap"});
    hold(fin, 1, {tag, " final"});
  endtask

  task automatic t_reset();
    hold(4'b0000, 3, "R1 in reset");
    rst_n = 1;
    hold(4'b0000, DT - 1, "R1 start-up gap");
    hold(4'b1001, 1, "R1 R4 first turn-on phase1");
  endtask

  task automatic t_phase_flip();
    apply(1, 0, 1, 0);
    step(4'b0000, 4'b0110, "R8 R3 phase 1->0 conducting");
    apply(1, 1, 1, 0);
    step(4'b0000, 4'b1001, "R8 R4 phase 0->1 conducting");
  endtask

  task automatic t_fast();
    apply(1, 1, 0, 0);
    step(4'b0000, 4'b0100, "R5 fast off phase1");
    apply(1, 1, 1, 0);
    step(4'b0000, 4'b1001, "R7 fast resume phase1");
    apply(1, 0, 1, 0);
    step(4'b0000, 4'b0110, "R8 flip to phase0");
    apply(1, 0, 0, 0);
    step(4'b0000, 4'b0001, "R5 fast off phase0");
    apply(1, 0, 1, 0);
    step(4'b0000, 4'b0110, "R7 fast resume phase0");
  endtask

  task automatic t_slow();
    apply(1, 0, 1, 1);
    hold(4'b0110, 2, "R4 mode bit idle while conducting");
    apply(1, 0, 0, 1);
    step(4'b0010, 4'b1010, "R6 slow off phase0");
    apply(1, 1, 0, 1);
    hold(4'b1010, DT + 2, "R6 phase ignored in slow off");
    apply(1, 1, 1, 1);
    step(4'b1000, 4'b1001, "R7 slow resume phase1");
    apply(1, 1, 0, 1);
    step(4'b1000, 4'b1010, "R6 slow off phase1");
    apply(1, 0, 1, 1);
    step(4'b0010, 4'b0110, "R7 slow resume phase0");
  endtask

  task automatic t_enable();
    apply(0, 0, 1, 1);
    hold(4'b0000, 20, "R9 disabled all off");
    apply(1, 0, 1, 1);
    hold(4'b0110, 1, "R9 long disable resumes next edge");
    apply(0, 0, 1, 1);
    @(negedge clk);
    checks++;
    if (gates() !== 4'b0000) begin
      errors++;
      $display("FAIL R9 short disable: got %b expected 0000", gates());
    end
    apply(1, 0, 1, 1);
    hold(4'b0000, DT - 1, "R9 short disable gap");
    hold(4'b0110, 1, "R9 short disable resume");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_phase_flip();
    t_fast();
    t_slow();
    t_enable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule